// File: doc/BRIEF.md
# Wavetable Register Decoder with Rotated Readback

This block sits between a host register window and a five-voice wavetable sound engine. The host presents an 8-bit offset, a data byte and a write or read strobe. The block stores one 32-byte signed waveform per voice and keeps the period, volume and enable settings for each voice. It also holds a test register whose bits change how the voice datapath counts and how waveform reads behave. The voice datapath lies outside this block. It supplies each voice's live playback index and receives the waveform byte at that index, together with the control settings.

Offset bits 7:5 select a 32-byte region and bits 4:0 select a byte inside it. There are two layouts. In the compatible layout, voices 3 and 4 share one waveform and the control registers are in region 4. In the extended layout, each of the five voices has its own waveform and the control registers move up to region 5. The layout is chosen by a mode input, and only the extended chip variant honours it.

When rotation is enabled, a waveform read is offset by the playback index of the voice being read, and waveform writes are blocked. Read data appears one clock after the read strobe.

Top module: `wt_regdec`

## Requirements
- R1: On a write in compatible mode, regions 0, 1 and 2 store into the waveform of voice 0, 1 and 2 at byte offset[4:0]. With rotation off, a read of the same offset returns that byte.
- R2: In compatible mode, a region 3 write stores into both voice 3 and voice 4. Region 3 reads back voice 3, region 5 reads back voice 4, and `sample_out` shows both voices.
- R3: In extended mode (extended chip with `ext_mode`=1), regions 0 to 4 write and read the independent waveforms of voices 0 to 4, and region 5 holds the control registers.
- R4: In the control region, offset[3:0] decodes as follows: 2n and 2n+1 are the low 8 and high 4 period bits of voice n (n = 0 to 4), 0xA+n is the 4-bit volume of voice n, and 0xF bit n is the enable of voice n. Offset bit 4 is ignored.
- R5: The test register is at region 6 on the extended chip and at region 7 on the basic chip. Bit 0 selects 4-bit frequency, bit 1 selects 8-bit frequency, bit 5 resets the position on a period write, bit 6 rotates all voices, and bit 7 rotates the voice 3/4 pair. Bit 7 is stored only on the basic chip.
- R6: While rotate-all is set, every waveform write is ignored.
- R7: In compatible mode, while rotate-pair is set, region 3 writes are ignored. Regions 0 to 2 are still written.
- R8: While rotate-all is set, a waveform read returns the byte at (offset[4:0] + playback index of that voice) mod 32.
- R9: In compatible mode, a region 3 read with rotate-pair set is offset by the index of voice 3. If rotate-all is also set, it is offset by the index of voice 4.
- R10: Reads of unmapped regions return 0xFF. These are regions 4, 6 and 7 in compatible mode and regions 5, 6 and 7 in extended mode.
- R11: `rdata` changes only on the clock edge that samples `rd_en` and holds otherwise. A read and a write to the same byte in one cycle return the previous contents.
- R12: After reset, all waveform bytes, control settings, test bits, `period_load` and `rdata` are zero.
- R13: A period byte write for voice n pulses `period_load` bit n for exactly one cycle after the write edge. No other write causes a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_mode | input | 1 | Selects the extended layout (extended chip only) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| voice_idx | input | 25 | Playback index per voice, 5 bits each, voice n at [5n+4:5n] |
| rdata | output | 8 | Read data, registered |
| sample_out | output | 40 | Waveform byte at each voice's playback index |
| period_out | output | 60 | 12-bit period per voice |
| volume_out | output | 20 | 4-bit volume per voice |
| enable_out | output | 5 | Voice enables |
| period_load | output | 5 | One-cycle pulse per voice after a period write |
| freq4_mode | output | 1 | Test bit: 4-bit frequency |
| freq8_mode | output | 1 | Test bit: 8-bit frequency |
| pos_reset_mode | output | 1 | Test bit: reset position on period write |
| rotate_all | output | 1 | Test bit: rotate all voices |
| rotate_pair | output | 1 | Test bit: rotate voice 3/4 pair |

## Verification
A host read and a host write to the same waveform byte can land on the same clock edge. The registered read path must then return the byte as it was before that edge. The bench raises both strobes in one cycle and compares `rdata` with the value its own model held before the write, then reads again to see the new byte. A second collision occurs when the playback index changes while rotation is active. The bench moves the indices between full read sweeps and recomputes every rotated address arithmetically.

// File: rtl/wt_regdec_pkg.sv
package wt_regdec_pkg;
  localparam int NV = 5;            // voices
  localparam int IW = 5;            // waveform index width
  localparam int WL = 1 << IW;      // waveform length
  localparam int DW = 8;            // data width
  localparam int PW = 12;           // period width
  localparam int VW = 4;            // volume width
  localparam int RW = 3;            // region field width

  localparam logic [RW-1:0] REG_CTRL_COMPAT = 3'd4;
  localparam logic [RW-1:0] REG_CTRL_EXT    = 3'd5;
  localparam logic [RW-1:0] REG_V4_READBACK = 3'd5;
  localparam logic [RW-1:0] REG_PAIR        = 3'd3;
  localparam logic [RW-1:0] REG_TEST_EXT    = 3'd6;
  localparam logic [RW-1:0] REG_TEST_BASIC  = 3'd7;

  typedef struct packed {
    logic rot_pair;
    logic rot_all;
    logic pos_reset;
    logic f8;
    logic f4;
  } test_t;

  function automatic logic [IW-1:0] wrap_index(input logic [IW-1:0] off,
                                               input logic [IW-1:0] pos);
    return off + pos;
  endfunction
endpackage

// File: rtl/wt_wave_ram.sv
module wt_wave_ram
  import wt_regdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NV-1:0]    we,
  input  logic [IW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [RW-1:0]    rvoice,
  input  logic [IW-1:0]    raddr,
  output logic [DW-1:0]    rword,
  input  logic [NV*IW-1:0] play_idx,
  output logic [NV*DW-1:0] play_word
);
  logic [DW-1:0] rsel [NV];

  for (genvar v = 0; v < NV; v++) begin : g_voice
    logic [DW-1:0] mem [WL];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < WL; i++) mem[i] <= '0;
      end else if (we[v]) begin
        mem[waddr] <= wdata;
      end
    end

    assign rsel[v] = mem[raddr];
    assign play_word[v*DW +: DW] = mem[play_idx[v*IW +: IW]];
  end

  always_comb begin
    rword = '0;
    for (int v = 0; v < NV; v++)
      if (int'(rvoice) == v) rword = rsel[v];
  end
endmodule

// File: rtl/wt_decode.sv
module wt_decode
  import wt_regdec_pkg::*;
#(
  parameter bit EXT_CHIP = 1'b1
) (
  input  logic [7:0]       addr,
  input  logic             wr_en,
  input  logic             ext_eff,
  input  test_t            tst,
  input  logic [NV*IW-1:0] play_idx,
  output logic [NV-1:0]    wave_we,
  output logic             ctrl_we,
  output logic             test_we,
  output logic             rd_mapped,
  output logic [RW-1:0]    rd_voice,
  output logic [IW-1:0]    rd_index
);
  localparam logic [RW-1:0] TEST_REGION = EXT_CHIP ? REG_TEST_EXT : REG_TEST_BASIC;

  logic [RW-1:0] region;
  logic [IW-1:0] off;
  logic [NV-1:0] wvec;
  logic [RW-1:0] pos_voice;
  logic          rotated;

  assign region = addr[7:5];
  assign off    = addr[IW-1:0];

  // write targets
  always_comb begin
    wvec = '0;
    if (ext_eff) begin
      if (region < RW'(NV)) wvec[region] = 1'b1;
    end else if (region < REG_PAIR) begin
      wvec[region] = 1'b1;
    end else if (region == REG_PAIR && !tst.rot_pair) begin
      wvec[3] = 1'b1;
      wvec[4] = 1'b1;
    end
  end

  assign wave_we = (wr_en && !tst.rot_all) ? wvec : '0;
  assign ctrl_we = wr_en && (region == (ext_eff ? REG_CTRL_EXT : REG_CTRL_COMPAT));
  assign test_we = wr_en && (region == TEST_REGION);

  // read target and rotation
  always_comb begin
    rd_mapped = 1'b0;
    rd_voice  = '0;
    if (ext_eff) begin
      if (region < RW'(NV)) begin
        rd_mapped = 1'b1;
        rd_voice  = region;
      end
    end else if (region <= REG_PAIR) begin
      rd_mapped = 1'b1;
      rd_voice  = region;
    end else if (region == REG_V4_READBACK) begin
      rd_mapped = 1'b1;
      rd_voice  = 3'd4;
    end

    pos_voice = rd_voice;
    rotated   = tst.rot_all;
    if (!ext_eff && region == REG_PAIR && (tst.rot_pair || tst.rot_all)) begin
      rotated   = 1'b1;
      pos_voice = tst.rot_all ? 3'd4 : 3'd3;
    end

    rd_index = rotated ? wrap_index(off, play_idx[int'(pos_voice)*IW +: IW]) : off;
  end
endmodule

// File: rtl/wt_ctrl_regs.sv
module wt_ctrl_regs
  import wt_regdec_pkg::*;
#(
  parameter bit EXT_CHIP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             test_we,
  input  logic [3:0]       nib,
  input  logic [DW-1:0]    wdata,
  output logic [NV*PW-1:0] period_out,
  output logic [NV*VW-1:0] volume_out,
  output logic [NV-1:0]    enable_out,
  output logic [NV-1:0]    period_load,
  output test_t            tst
);
  localparam int VOL_BASE = 2 * NV;
  localparam int EN_SLOT  = 15;

  logic [PW-1:0] per [NV];
  logic [VW-1:0] vol [NV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin
        per[v] <= '0;
        vol[v] <= '0;
      end
      enable_out  <= '0;
      period_load <= '0;
      tst         <= '0;
    end else begin
      period_load <= '0;
      if (ctrl_we) begin
        for (int v = 0; v < NV; v++) begin
          if (int'(nib) == 2*v) begin
            per[v][DW-1:0] <= wdata;
            period_load[v] <= 1'b1;
          end
          if (int'(nib) == 2*v + 1) begin
            per[v][PW-1:DW] <= wdata[PW-DW-1:0];
            period_load[v]  <= 1'b1;
          end
          if (int'(nib) == VOL_BASE + v) vol[v] <= wdata[VW-1:0];
        end
        if (int'(nib) == EN_SLOT) enable_out <= wdata[NV-1:0];
      end
      if (test_we) begin
        tst.f4        <= wdata[0];
        tst.f8        <= wdata[1];
        tst.pos_reset <= wdata[5];
        tst.rot_all   <= wdata[6];
        tst.rot_pair  <= wdata[7] & ~EXT_CHIP;
      end
    end
  end

  for (genvar v = 0; v < NV; v++) begin : g_flat
    assign period_out[v*PW +: PW] = per[v];
    assign volume_out[v*VW +: VW] = vol[v];
  end
endmodule

// File: rtl/wt_regdec.sv
module wt_regdec
  import wt_regdec_pkg::*;
#(
  parameter bit EXT_CHIP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NV*IW-1:0] voice_idx,
  output logic [DW-1:0]    rdata,
  output logic [NV*DW-1:0] sample_out,
  output logic [NV*PW-1:0] period_out,
  output logic [NV*VW-1:0] volume_out,
  output logic [NV-1:0]    enable_out,
  output logic [NV-1:0]    period_load,
  output logic             freq4_mode,
  output logic             freq8_mode,
  output logic             pos_reset_mode,
  output logic             rotate_all,
  output logic             rotate_pair
);
  logic          ext_eff;
  test_t         tst;
  logic [NV-1:0] wave_we;
  logic          ctrl_we;
  logic          test_we;
  logic          rd_mapped;
  logic [RW-1:0] rd_voice;
  logic [IW-1:0] rd_index;
  logic [DW-1:0] ram_word;

  assign ext_eff = EXT_CHIP && ext_mode;

  wt_decode #(.EXT_CHIP(EXT_CHIP)) u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .ext_eff  (ext_eff),
    .tst      (tst),
    .play_idx (voice_idx),
    .wave_we  (wave_we),
    .ctrl_we  (ctrl_we),
    .test_we  (test_we),
    .rd_mapped(rd_mapped),
    .rd_voice (rd_voice),
    .rd_index (rd_index)
  );

  wt_wave_ram u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wave_we),
    .waddr    (addr[IW-1:0]),
    .wdata    (wdata),
    .rvoice   (rd_voice),
    .raddr    (rd_index),
    .rword    (ram_word),
    .play_idx (voice_idx),
    .play_word(sample_out)
  );

  wt_ctrl_regs #(.EXT_CHIP(EXT_CHIP)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .test_we    (test_we),
    .nib        (addr[3:0]),
    .wdata      (wdata),
    .period_out (period_out),
    .volume_out (volume_out),
    .enable_out (enable_out),
    .period_load(period_load),
    .tst        (tst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mapped ? ram_word : {DW{1'b1}};
  end

  assign freq4_mode     = tst.f4;
  assign freq8_mode     = tst.f8;
  assign pos_reset_mode = tst.pos_reset;
  assign rotate_all     = tst.rot_all;
  assign rotate_pair    = tst.rot_pair;
endmodule

// File: rtl/wt_regdec_chk.sv
module wt_regdec_chk
  import wt_regdec_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ext_eff,
  input logic          rot_all,
  input logic          rot_pair,
  input logic [7:0]    addr,
  input logic [DW-1:0] rdata,
  input logic [NV-1:0] wave_we,
  input logic [NV-1:0] period_load
);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_unmapped_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[7:5] == 3'd7) |=> rdata == 8'hFF);

  p_rot_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rot_all |-> wave_we == '0);

  p_pair_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_pair && !ext_eff) |-> wave_we[4:3] == 2'b00);

  p_pair_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_eff && wave_we[3]) |-> wave_we[4]);

  p_load_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(period_load));

  p_load_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (period_load != '0) |-> $past(wr_en));
endmodule

bind wt_regdec wt_regdec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .ext_eff    (ext_eff),
  .rot_all    (tst.rot_all),
  .rot_pair   (tst.rot_pair),
  .addr       (addr),
  .rdata      (rdata),
  .wave_we    (wave_we),
  .period_load(period_load)
);

// File: tb/wt_regdec_test.sv
module wt_regdec_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [4:0] vidx [5];
  logic [24:0] voice_idx;

  logic [7:0]  rd_q [2];
  logic [39:0] smp [2];
  logic [59:0] per [2];
  logic [19:0] vol [2];
  logic [4:0]  en [2];
  logic [4:0]  ld [2];
  logic f4 [2];
  logic f8 [2];
  logic pr [2];
  logic ra [2];
  logic rp [2];

  // bench model: instance 0 = extended chip, instance 1 = basic chip
  logic [7:0]  mw [2][5][32];
  logic [11:0] mper [2][5];
  logic [3:0]  mvol [2][5];
  logic [4:0]  men [2];
  logic [4:0]  mtst [2];   // {pair, all, pos_reset, f8, f4}

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign voice_idx = {vidx[4], vidx[3], vidx[2], vidx[1], vidx[0]};

  wt_regdec #(.EXT_CHIP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .voice_idx(voice_idx), .rdata(rd_q[0]),
    .sample_out(smp[0]), .period_out(per[0]), .volume_out(vol[0]),
    .enable_out(en[0]), .period_load(ld[0]), .freq4_mode(f4[0]),
    .freq8_mode(f8[0]), .pos_reset_mode(pr[0]), .rotate_all(ra[0]),
    .rotate_pair(rp[0]));

  wt_regdec #(.EXT_CHIP(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .voice_idx(voice_idx), .rdata(rd_q[1]),
    .sample_out(smp[1]), .period_out(per[1]), .volume_out(vol[1]),
    .enable_out(en[1]), .period_load(ld[1]), .freq4_mode(f4[1]),
    .freq8_mode(f8[1]), .pos_reset_mode(pr[1]), .rotate_all(ra[1]),
    .rotate_pair(rp[1]));

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit m_ext(input int i);
    return (i == 0) && ext_mode;
  endfunction

  function automatic logic [7:0] m_rd(input int i, input logic [7:0] a);
    int r, o, v, pv;
    bit rot;
    r = int'(a[7:5]);
    o = int'(a[4:0]);
    v = -1;
    if (m_ext(i)) begin
      if (r <= 4) v = r;
    end else begin
      if (r <= 3) v = r;
      else if (r == 5) v = 4;
    end
    if (v < 0) return 8'hFF;
    rot = mtst[i][3];
    pv = v;
    if (!m_ext(i) && r == 3 && (mtst[i][4] || mtst[i][3])) begin
      rot = 1'b1;
      pv = mtst[i][3] ? 4 : 3;
    end
    if (rot) o = (o + int'(vidx[pv])) % 32;
    return mw[i][v][o];
  endfunction

  // returns the expected period-load vector
  function automatic logic [4:0] m_wr(input int i, input logic [7:0] a, input logic [7:0] d);
    int r, o, n;
    bit ext, all, pair, ctrl;
    logic [4:0] lv;
    lv = '0;
    r = int'(a[7:5]);
    o = int'(a[4:0]);
    n = int'(a[3:0]);
    ext = m_ext(i);
    all = mtst[i][3];
    pair = mtst[i][4];
    ctrl = 1'b0;
    if (ext) begin
      if (r <= 4 && !all) mw[i][r][o] = d;
      if (r == 5) ctrl = 1'b1;
    end else begin
      if (r <= 2 && !all) mw[i][r][o] = d;
      if (r == 3 && !all && !pair) begin
        mw[i][3][o] = d;
        mw[i][4][o] = d;
      end
      if (r == 4) ctrl = 1'b1;
    end
    if (ctrl) begin
      if (n < 10) begin
        if (n % 2 == 0) mper[i][n/2][7:0] = d;
        else mper[i][n/2][11:8] = d[3:0];
        lv[n/2] = 1'b1;
      end else if (n < 15) begin
        mvol[i][n-10] = d[3:0];
      end else begin
        men[i] = d[4:0];
      end
    end
    if ((i == 0 && r == 6) || (i == 1 && r == 7))
      mtst[i] = {(i == 1) ? d[7] : 1'b0, d[6], d[5], d[1], d[0]};
    return lv;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [4:0] e0, e1;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    e0 = m_wr(0, a, d);
    e1 = m_wr(1, a, d);
    check(ld[0] == e0, "R13 period_load ext chip", 64'(ld[0]), 64'(e0));
    check(ld[1] == e1, "R13 period_load basic chip", 64'(ld[1]), 64'(e1));
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    for (int i = 0; i < 2; i++)
      check(rd_q[i] == m_rd(i, a), $sformatf("%s inst%0d addr %02h", tag, i, a),
            64'(rd_q[i]), 64'(m_rd(i, a)));
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 256; a++) rd_chk(8'(a), tag);
  endtask

  task automatic samp_chk(input string tag);
    for (int i = 0; i < 2; i++)
      for (int v = 0; v < 5; v++)
        check(smp[i][v*8 +: 8] == mw[i][v][vidx[v]],
              $sformatf("%s sample inst%0d voice%0d", tag, i, v),
              64'(smp[i][v*8 +: 8]), 64'(mw[i][v][vidx[v]]));
  endtask

  task automatic outs_chk(input string tag);
    for (int i = 0; i < 2; i++) begin
      for (int v = 0; v < 5; v++) begin
        check(per[i][v*12 +: 12] == mper[i][v], $sformatf("%s period inst%0d v%0d", tag, i, v),
              64'(per[i][v*12 +: 12]), 64'(mper[i][v]));
        check(vol[i][v*4 +: 4] == mvol[i][v], $sformatf("%s volume inst%0d v%0d", tag, i, v),
              64'(vol[i][v*4 +: 4]), 64'(mvol[i][v]));
      end
      check(en[i] == men[i], $sformatf("%s enable inst%0d", tag, i), 64'(en[i]), 64'(men[i]));
      check({rp[i], ra[i], pr[i], f8[i], f4[i]} == mtst[i],
            $sformatf("R5 %s test bits inst%0d", tag, i),
            64'({rp[i], ra[i], pr[i], f8[i], f4[i]}), 64'(mtst[i]));
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + 11 + k * 101) ^ (k * 23));
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG_LIMIT) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG_LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] old0, old1, hold0, hold1;
    for (int i = 0; i < 2; i++) begin
      for (int v = 0; v < 5; v++) begin
        for (int k = 0; k < 32; k++) mw[i][v][k] = 8'h00;
        mper[i][v] = '0;
        mvol[i][v] = '0;
      end
      men[i] = '0;
      mtst[i] = '0;
    end
    vidx[0] = 5'd3; vidx[1] = 5'd17; vidx[2] = 5'd30; vidx[3] = 5'd9; vidx[4] = 5'd21;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    for (int i = 0; i < 2; i++) begin
      check(rd_q[i] == 8'h00, "R12 rdata after reset", 64'(rd_q[i]), 64'h0);
      check(ld[i] == 5'h00, "R12 period_load after reset", 64'(ld[i]), 64'h0);
    end
    samp_chk("R12");
    outs_chk("R12");

    // compatible layout fill and sweep
    for (int a = 0; a < 128; a++) wr(8'(a), pat(a, 1));
    sweep("R1/R2/R10 compat");
    samp_chk("R2 compat");

    // control registers, mirror through offset bit 4
    for (int v = 0; v < 5; v++) begin
      wr(8'(8'h80 + 2*v), 8'(8'h10 + 16*v + v));
      wr(8'(8'h91 + 2*v), 8'(8'hA0 + v + 5));
      wr(8'(8'h8A + v), 8'(8'hF0 + 3*v));
    end
    wr(8'h9F, 8'hEA);
    outs_chk("R4 compat");

    // extended layout
    ext_mode = 1'b1;
    wr(8'hA4, 8'h5C);
    wr(8'hBB, 8'h07);
    outs_chk("R3/R4 ext ctrl");
    for (int a = 0; a < 160; a++) wr(8'(a), pat(a, 2));
    sweep("R3/R10 ext");
    samp_chk("R3 ext");
    outs_chk("R3 ext");

    // test register placement and bits
    wr(8'hC0, 8'hA3);
    wr(8'hE0, 8'h22);
    outs_chk("test place");
    wr(8'hC0, 8'h00);
    wr(8'hE0, 8'h00);

    // rotate-all on the extended chip
    wr(8'hC0, 8'h40);
    outs_chk("rot all");
    wr(8'h00, 8'h55);
    wr(8'h25, 8'h56);
    wr(8'h9F, 8'h57);
    sweep("R6/R8 rot ext");
    vidx[0] = 5'd31; vidx[1] = 5'd1; vidx[2] = 5'd16; vidx[3] = 5'd27; vidx[4] = 5'd5;
    sweep("R8 rot moved idx");
    samp_chk("R8");

    // basic chip pair rotation in compatible mode
    ext_mode = 1'b0;
    wr(8'hC0, 8'h00);
    wr(8'hE0, 8'h80);
    outs_chk("pair");
    wr(8'h61, 8'h77);
    wr(8'h7F, 8'h78);
    wr(8'h05, 8'h79);
    sweep("R7/R9 pair");
    wr(8'hE0, 8'hC0);
    sweep("R9 pair+all");
    wr(8'h40, 8'h7A);
    wr(8'hE0, 8'h00);
    sweep("R6/R9 after rot");

    // R11: read and write to one byte in one cycle
    @(negedge clk);
    old0 = m_rd(0, 8'h42);
    old1 = m_rd(1, 8'h42);
    addr = 8'h42; wdata = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_q[0] == old0, "R11 same-cycle read ext chip", 64'(rd_q[0]), 64'(old0));
    check(rd_q[1] == old1, "R11 same-cycle read basic chip", 64'(rd_q[1]), 64'(old1));
    void'(m_wr(0, 8'h42, 8'h3C));
    void'(m_wr(1, 8'h42, 8'h3C));
    rd_chk(8'h42, "R11 read after collision");

    // R11: hold without strobe
    hold0 = rd_q[0];
    hold1 = rd_q[1];
    @(negedge clk);
    addr = 8'hE0;
    repeat (3) @(negedge clk);
    check(rd_q[0] == hold0, "R11 hold ext chip", 64'(rd_q[0]), 64'(hold0));
    check(rd_q[1] == hold1, "R11 hold basic chip", 64'(rd_q[1]), 64'(hold1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule